// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer with a 32-bit down-counter, controlled through a register port that completes each read and write in a single cycle. Software loads a reload value and sets the count-enable bit. From then on the counter steps down once on every cycle in which the tick-enable input is high. Each time the counter passes through zero it reloads and raises an interrupt. If the interrupt is still pending at the next zero and the reset-enable bit is set, a reset request output goes high and stays high.

A write guard protects the registers. While the guard is closed, the block drops every write to the reload, control and acknowledge registers. Writing the unlock key to the guard register opens it, and writing any other value closes it again. The intended software sequence is: unlock, change the configuration, lock again. The interrupt service routine follows the same sequence: unlock, acknowledge, lock.

Register word addresses: 0 reload value, 1 current count, 2 control, 3 acknowledge, 4 guard.

Top module: `wdt_guard`

## Requirements
- R1: After reset the guard is open (guard reads 0), control reads 0, the reload value and the current count both read 32'hFFFF_FFFF, and irqOut and rstReqOut are low.
- R2: A write of 32'h1ACC_E551 to the guard register (address 4) opens the guard, and it then reads 0. A write of any other value closes the guard, and it then reads 1. The guard register accepts writes in either state.
- R3: While the guard is closed, writes to addresses 0, 2 and 3 change no register, the count, or the interrupt state.
- R4: Control bit 0 is count-enable and bit 1 is reset-enable. Reading address 2 returns these two bits, with all other bits 0. A write that sets count-enable while it was clear loads the count from the reload register.
- R5: While count-enable is set, and on a cycle with tickEn high and no counter-affecting write, a nonzero count decrements. A zero count reloads from the reload register and sets the pending interrupt. A reload value N therefore raises irqOut on the (N+1)-th tick.
- R6: While count-enable is clear, the count holds its value. A later set restarts the count from the reload register, not from the held value.
- R7: A write of any data to address 3 while the guard is open clears the pending interrupt and reloads the count from the reload register.
- R8: A write to address 0 while the guard is open stores the new reload value and loads the count with it in the same cycle.
- R9: A zero event that occurs while the interrupt is still pending and reset-enable is set drives rstReqOut high. rstReqOut then stays high until reset. With reset-enable clear, repeated zero events leave rstReqOut low.
- R10: rdData is combinational from addr: address 0 the reload value, 1 the count, 2 control, 4 the guard state, and 0 for address 3 and for every unused address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count tick qualifier |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| irqOut | output | 1 | Pending timeout interrupt |
| rstReqOut | output | 1 | Sticky last-resort reset request |

## Verification
The embedded properties check on every cycle the properties that hold cycle by cycle. A closed guard freezes the configuration. The guard decodes the key. A disabled counter holds its value. An acknowledge clears the interrupt, and a reload write takes effect at once. The reset request is sticky, and it rises only from a pending interrupt with reset-enable set. The exact tick on which the interrupt and the reset fire can only be shown by the bench's scenarios, since it depends on the reload value and on the tick pattern. The same holds for restarting from the reload value after a disable, and for the full read map. A behavioural model in the bench covers these on every clock.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Register word addresses; software relies on these values
  typedef enum logic [2:0] {
    REG_RELOAD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_ACK    = 3'd3,
    REG_GUARD  = 3'd4
  } wdtReg_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeNew;    // load count from write data
    logic takeSaved;  // load count from reload register
    logic ackIrq;     // clear pending interrupt
    logic run;        // count-enable
    logic rstArm;     // reset-enable
  } wdtCmd_t;

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] reloadVal,
  output wdtCmd_t           cmd
);

  localparam int CTRL_PAD  = DATA_W - 2;
  localparam int GUARD_PAD = DATA_W - 1;

  logic locked;
  logic [DATA_W-1:0] reloadReg;
  logic runBit;
  logic armBit;

  logic hitReload, hitCtrl, hitAck, hitGuard, hitCount;
  logic wrOpen;

  assign hitReload = (addr == ADDR_W'(REG_RELOAD));
  assign hitCount  = (addr == ADDR_W'(REG_COUNT));
  assign hitCtrl   = (addr == ADDR_W'(REG_CTRL));
  assign hitAck    = (addr == ADDR_W'(REG_ACK));
  assign hitGuard  = (addr == ADDR_W'(REG_GUARD));
  assign wrOpen    = wrEn && !locked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked    <= 1'b0;
      reloadReg <= '1;
      runBit    <= 1'b0;
      armBit    <= 1'b0;
    end else begin
      if (wrEn && hitGuard) begin
        locked <= (wrData != UNLOCK_KEY);
      end
      if (wrOpen && hitReload) begin
        reloadReg <= wrData;
      end
      if (wrOpen && hitCtrl) begin
        runBit <= wrData[0];
        armBit <= wrData[1];
      end
    end
  end

  always_comb begin
    cmd.takeNew   = wrOpen && hitReload;
    cmd.takeSaved = wrOpen && (hitAck || (hitCtrl && wrData[0] && !runBit));
    cmd.ackIrq    = wrOpen && hitAck;
    cmd.run       = runBit;
    cmd.rstArm    = armBit;
  end

  assign reloadVal = reloadReg;

  always_comb begin
    rdData = '0;
    if (hitReload)     rdData = reloadReg;
    else if (hitCount) rdData = countVal;
    else if (hitCtrl)  rdData = {{CTRL_PAD{1'b0}}, armBit, runBit};
    else if (hitGuard) rdData = {{GUARD_PAD{1'b0}}, locked};
  end

  // R3
  locked_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && locked && !hitGuard) |=> ($stable(reloadReg) && $stable(runBit) && $stable(armBit)));

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitGuard && (wrData == UNLOCK_KEY)) |=> !locked);

  // R2
  other_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitGuard && (wrData != UNLOCK_KEY)) |=> locked);

endmodule

// File: rtl/wdt_guard_dp.sv
module wdt_guard_dp
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  wdtCmd_t           cmd,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic [DATA_W-1:0] newVal,
  output logic [DATA_W-1:0] countVal,
  output logic              irqOut,
  output logic              rstReqOut
);

  logic [DATA_W-1:0] count;
  logic irqPend;
  logic rstReq;
  logic atZero;
  logic stepNow;

  assign atZero  = (count == '0);
  assign stepNow = cmd.run && tickEn && !cmd.takeNew && !cmd.takeSaved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '1;
      irqPend <= 1'b0;
      rstReq  <= 1'b0;
    end else if (cmd.takeNew) begin
      count <= newVal;
    end else if (cmd.takeSaved) begin
      count <= reloadVal;
      if (cmd.ackIrq) irqPend <= 1'b0;
    end else if (stepNow) begin
      if (atZero) begin
        count   <= reloadVal;
        irqPend <= 1'b1;
        if (irqPend && cmd.rstArm) rstReq <= 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  assign countVal  = count;
  assign irqOut    = irqPend;
  assign rstReqOut = rstReq;

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.takeNew && !cmd.takeSaved) |=> $stable(countVal));

  // R5
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(countVal) == '0));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ackIrq |=> !irqOut);

  // R8
  load_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.takeNew |=> (countVal == $past(newVal)));

  // R9
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |=> rstReqOut);

  // R9
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReqOut) |-> ($past(irqOut) && $past(cmd.rstArm)));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstReqOut
);

  wdtCmd_t           cmd;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] countVal;

  wdt_guard_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .countVal(countVal), .rdData(rdData), .reloadVal(reloadVal), .cmd(cmd)
  );

  wdt_guard_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd),
    .reloadVal(reloadVal), .newVal(wrData),
    .countVal(countVal), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut, rstReqOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0] mReload, mCount;
  logic mLocked, mRun, mArm, mIrq, mRst;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReload = 32'hFFFF_FFFF; mCount = 32'hFFFF_FFFF;
      mLocked = 0; mRun = 0; mArm = 0; mIrq = 0; mRst = 0;
    end else begin
      logic busy;
      logic oldRun;
      busy = 0;
      oldRun = mRun;
      if (wrEn && addr == 3'd4) begin
        mLocked = (wrData != KEY);
      end else if (wrEn && !mLocked) begin
        if (addr == 3'd0) begin
          mReload = wrData; mCount = wrData; busy = 1;
        end else if (addr == 3'd2) begin
          if (wrData[0] && !oldRun) begin mCount = mReload; busy = 1; end
          mRun = wrData[0]; mArm = wrData[1];
        end else if (addr == 3'd3) begin
          mIrq = 0; mCount = mReload; busy = 1;
        end
      end
      if (oldRun && tickEn && !busy) begin
        if (mCount == 0) begin
          if (mIrq && mArm) mRst = 1;
          mIrq = 1;
          mCount = mReload;
        end else begin
          mCount = mCount - 1;
        end
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mReload;
      3'd1: return mCount;
      3'd2: return {30'd0, mArm, mRun};
      3'd4: return {31'd0, mLocked};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, then compare with the model at the next negedge
  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
    wrEn = w; addr = a; wrData = d; tickEn = t;
    @(negedge clk);
    check({curReq, " irq"}, {31'd0, irqOut}, {31'd0, mIrq});
    check({curReq, " rst"}, {31'd0, rstReqOut}, {31'd0, mRst});
    check({curReq, " rd"}, rdData, modelRead(a));
  endtask

  task automatic doReset();
    wrEn = 0; tickEn = 0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // R1 reset state
    curReq = "R1";
    step(0, 3'd4, 0, 0); check("R1 guard", rdData, 32'd0);
    step(0, 3'd0, 0, 0); check("R1 reload", rdData, 32'hFFFF_FFFF);
    step(0, 3'd1, 0, 0); check("R1 count", rdData, 32'hFFFF_FFFF);
    step(0, 3'd2, 0, 0); check("R1 ctrl", rdData, 32'd0);

    // R2 guard
    curReq = "R2";
    step(1, 3'd4, 32'h1234_5678, 0);
    step(0, 3'd4, 0, 0); check("R2 closed", rdData, 32'd1);
    step(1, 3'd4, KEY, 0);
    step(0, 3'd4, 0, 0); check("R2 opened", rdData, 32'd0);
    step(1, 3'd4, KEY ^ 32'h1, 0);
    step(0, 3'd4, 0, 0); check("R2 near key", rdData, 32'd1);

    // R3 writes ignored while closed
    curReq = "R3";
    step(1, 3'd0, 32'd7, 1);
    step(1, 3'd2, 32'd3, 1);
    step(1, 3'd3, 32'd0, 1);
    step(0, 3'd0, 0, 0); check("R3 reload", rdData, 32'hFFFF_FFFF);
    step(0, 3'd2, 0, 0); check("R3 ctrl", rdData, 32'd0);
    step(0, 3'd1, 0, 0); check("R3 count", rdData, 32'hFFFF_FFFF);

    // R8 reload write, R4 start, R5 countdown
    curReq = "R8";
    step(1, 3'd4, KEY, 0);
    step(1, 3'd0, 32'd5, 0);
    step(0, 3'd1, 0, 0); check("R8 count", rdData, 32'd5);
    curReq = "R4";
    step(1, 3'd2, 32'd1, 0);
    step(0, 3'd2, 0, 0); check("R4 ctrl", rdData, 32'd1);
    curReq = "R5";
    for (int k = 0; k < 5; k++) step(0, 3'd1, 0, 1);
    check("R5 no irq after 5 ticks", {31'd0, irqOut}, 32'd0);
    step(0, 3'd1, 0, 1);
    check("R5 irq on 6th tick", {31'd0, irqOut}, 32'd1);
    check("R5 reloaded", rdData, 32'd5);
    // gapped ticks
    for (int k = 0; k < 8; k++) step(0, 3'd1, 0, k[0]);

    // R7 acknowledge
    curReq = "R7";
    step(1, 3'd3, 32'hDEAD_BEEF, 1);
    step(0, 3'd1, 0, 0);
    check("R7 irq cleared", {31'd0, irqOut}, 32'd0);
    check("R7 count reloaded", rdData, 32'd5);

    // R6 halt and restart from reload
    curReq = "R6";
    step(0, 3'd1, 0, 1);
    step(0, 3'd1, 0, 1);
    step(1, 3'd2, 32'd0, 0);
    for (int k = 0; k < 4; k++) step(0, 3'd1, 0, 1);
    check("R6 held", rdData, 32'd3);
    step(1, 3'd2, 32'd1, 0);
    step(0, 3'd1, 0, 0); check("R6 restart", rdData, 32'd5);

    // R8 reload while counting
    curReq = "R8";
    step(1, 3'd0, 32'd20, 1);
    step(0, 3'd1, 0, 0); check("R8 new while running", rdData, 32'd20);

    // R9 no reset with reset-enable clear
    curReq = "R9";
    step(1, 3'd0, 32'd3, 0);
    for (int k = 0; k < 12; k++) step(0, 3'd1, 0, 1);
    check("R9 pending", {31'd0, irqOut}, 32'd1);
    check("R9 no reset when disarmed", {31'd0, rstReqOut}, 32'd0);
    step(1, 3'd2, 32'd3, 0);
    for (int k = 0; k < 5; k++) step(0, 3'd1, 0, 1);
    check("R9 reset asserted", {31'd0, rstReqOut}, 32'd1);
    step(1, 3'd3, 0, 1);
    step(1, 3'd2, 32'd0, 0);
    step(0, 3'd2, 0, 0); check("R9 reset sticky", {31'd0, rstReqOut}, 32'd1);

    // R10 read map
    curReq = "R10";
    for (int a = 3; a < 8; a++) step(0, a[2:0], 0, 0);
    step(0, 3'd3, 0, 0); check("R10 ack reads zero", rdData, 32'd0);
    step(0, 3'd6, 0, 0); check("R10 unused reads zero", rdData, 32'd0);

    // R1 again after mid-run reset
    doReset();
    curReq = "R1";
    step(0, 3'd1, 0, 1); check("R1 count after reset", rdData, 32'hFFFF_FFFF);
    check("R1 rst low", {31'd0, rstReqOut}, 32'd0);
    check("R1 irq low", {31'd0, irqOut}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule